// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the bus-facing control and status side of a hash accelerator. Software reaches it through a simple 32-bit register port. It selects the operating options and the interrupt mask, starts a job, and streams message bytes into an internal buffer. It then hands the buffered message to the hash engine and polls a sticky completion flag. When the job is finished, software reads back the eight result words.

A three-state controller sequences the job. In the waiting state, options can be written and a start command opens a fresh message. In the collecting state, byte-wide and word-wide writes to the message window append to one little-endian byte stream. A process command hands the stream to the engine, and the controller stays in the working state until the engine answers. The hash computation itself lives outside this block. A plain start/done port carries the message, its length and the returned 256-bit result.

Byte offsets used below: options 0x00, interrupt mask 0x04, flags 0x08, command 0x0C, status 0x10, result words 0x20 to 0x3C, message window 0x40 to 0x7F. The status word carries the controller state in bits 1:0 (0 waiting, 1 collecting, 2 working), the sticky overflow bit in bit 2 and the buffer fill count in bits 14:8.

Top module: `hash_frontend`

## Requirements
- R1: After reset the controller is waiting, and the options, interrupt mask, flags and status registers all read 0.
- R2: In the waiting state, a write to 0x00 stores bits 3:0 of the data, and the other bits read back as 0. A write to 0x04 keeps only bits 2:0. Both writes are ignored in any other state.
- R3: Flag bit 0 (done) at 0x08 is write-one-to-clear. Writing 1 in bit 0 clears it, and writing 0 there leaves it unchanged.
- R4: Writing command bit 0 (start) in the waiting state moves the controller to collecting, empties the buffer and clears the overflow bit. A start in any other state is ignored.
- R5: While collecting, a write to the message window with `bus_wsize`=0 appends data bits 7:0. A write with `bus_wsize`=1 appends four bytes, bits 7:0 first. Byte k of the stream appears on `eng_msg[8k+7:8k]`. Writes to the window outside collecting are ignored.
- R6: Writing command bit 1 (process) while collecting moves the controller to working. On the next edge `eng_start` pulses for exactly one cycle, with `eng_len` equal to the byte count. A process command in any other state is ignored.
- R7: `eng_done` while working latches `eng_digest`, sets the done flag whatever the interrupt mask holds, and returns the controller to waiting.
- R8: In the waiting state, result word i (`eng_digest[32i+31:32i]`, i = 0 to 7) reads at 0x3C − 4·i. Outside the waiting state these addresses read 0.
- R9: The buffer holds 64 bytes. A push that does not fit is dropped whole, and it sets the sticky overflow bit in status bit 2.
- R10: An access to an unaligned address, or to an address at or above 0x80, raises `bus_err` in the same cycle, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wsize | input | 1 | Message push width: 0 byte, 1 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Invalid address in this access |
| eng_start | output | 1 | One-cycle job start |
| eng_len | output | 7 | Message length in bytes |
| eng_msg | output | 512 | Buffered message, byte k at bits 8k+7:8k |
| eng_cfg | output | 4 | Option bits forwarded to the engine |
| eng_done | input | 1 | Engine finished |
| eng_digest | input | 256 | Engine result, word i at bits 32i+31:32i |

## Verification
The assertions check a set of rules on every cycle. Options never change outside the waiting state. A done-flag clear always takes effect, and an engine answer always sets the flag and returns the controller to waiting. The start pulse lasts one cycle and only comes while working. The fill count never exceeds the buffer size, does not move while working, and an address error always reads 0. Some behaviours only the directed scenarios can show: the byte order of mixed byte and word pushes, the reversed placement of the result words, the drop-whole rule at the buffer boundary, and the fact that commands given in the wrong state leave no trace at the ports.

// File: rtl/hfe_pkg.sv
// Shared types and register offsets of the hash front-end.
// Assumes byte addressing with 32-bit aligned registers.
package hfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONS = 2'd1,
        ST_PROC = 2'd2
    } state_e;

    localparam int unsigned DIG_WORDS = 8;
    localparam int unsigned OFF_CFG   = 32'h00;
    localparam int unsigned OFF_IE    = 32'h04;
    localparam int unsigned OFF_FLAG  = 32'h08;
    localparam int unsigned OFF_CMD   = 32'h0C;
    localparam int unsigned OFF_STAT  = 32'h10;
    localparam int unsigned OFF_DIGHI = 32'h3C;
    localparam int unsigned OFF_DIGLO = OFF_DIGHI - 4 * (DIG_WORDS - 1);
    localparam int unsigned OFF_FIFO  = 32'h40;
endpackage

// File: rtl/hfe_ctrl.sv
// Job sequencer: waiting -> collecting -> working -> waiting.
// Assumes commands arrive already decoded; drops those illegal in the current state.
module hfe_ctrl
    import hfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_start,
    input  logic   cmd_proc,
    input  logic   eng_done,
    output state_e state,
    output logic   eng_start,
    output logic   buf_clear,
    output logic   latch_res
);
    // Advance the job state and issue the one-cycle engine start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            eng_start <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_start) state <= ST_CONS;
                ST_CONS: if (cmd_proc) begin
                    state     <= ST_PROC;
                    eng_start <= 1'b1;
                end
                ST_PROC: if (eng_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Side effects of legal transitions.
    always_comb begin
        buf_clear = (state == ST_IDLE) && cmd_start;
        latch_res = (state == ST_PROC) && eng_done;
    end
endmodule

// File: rtl/hfe_msg_buf.sv
// Message byte buffer with byte and little-endian word append.
// Assumes the caller only pushes while collecting; a push that does not fit is dropped whole.
module hfe_msg_buf #(
    parameter int MAX_BYTES = 64,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   push_byte,
    input  logic                   push_word,
    input  logic [31:0]            wdata,
    output logic [MAX_BYTES*8-1:0] msg,
    output logic [CNT_W-1:0]       count,
    output logic                   ovf
);
    logic [7:0] mem [MAX_BYTES];

    // Append bytes, track fill level and the sticky overflow bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            for (int k = 0; k < MAX_BYTES; k++) mem[k] <= 8'h00;
        end else if (clear) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (push_byte) begin
            if (count < CNT_W'(MAX_BYTES)) begin
                mem[IDX_W'(count)] <= wdata[7:0];
                count <= count + CNT_W'(1);
            end else begin
                ovf <= 1'b1;
            end
        end else if (push_word) begin
            if (count <= CNT_W'(MAX_BYTES - 4)) begin
                for (int j = 0; j < 4; j++)
                    mem[IDX_W'(count + CNT_W'(j))] <= wdata[8*j +: 8];
                count <= count + CNT_W'(4);
            end else begin
                ovf <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < MAX_BYTES; g++) begin : g_flat
            assign msg[8*g +: 8] = mem[g];
        end
    endgenerate
endmodule

// File: rtl/hfe_result.sv
// Result word store: captures the engine output and serves one word by index.
// Assumes the index is in range whenever the word is used.
module hfe_result #(
    parameter int WORDS = 8,
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               latch,
    input  logic [WORDS*32-1:0] din,
    input  logic [SEL_W-1:0]   sel,
    output logic [31:0]        dout
);
    logic [31:0] words [WORDS];

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            // Hold one result word until the next job completes.
            always_ff @(posedge clk) begin
                if (!rst_n)     words[g] <= '0;
                else if (latch) words[g] <= din[32*g +: 32];
            end
        end
    endgenerate

    assign dout = words[sel];
endmodule

// File: rtl/hash_frontend.sv
// Register front-end of a hash accelerator: decodes the bus, holds options,
// interrupt mask and the write-one-to-clear done flag, and wires the sequencer,
// message buffer and result store. Assumes single-cycle bus accesses.
module hash_frontend
    import hfe_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MAX_BYTES = 64,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int SEL_W    = $clog2(DIG_WORDS),
    localparam int WIN_END  = OFF_FIFO + MAX_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic                      bus_re,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wsize,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_err,
    output logic                      eng_start,
    output logic [CNT_W-1:0]          eng_len,
    output logic [MAX_BYTES*8-1:0]    eng_msg,
    output logic [3:0]                eng_cfg,
    input  logic                      eng_done,
    input  logic [DIG_WORDS*32-1:0]   eng_digest
);
    state_e           state;
    logic [3:0]       cfg;
    logic [2:0]       ie;
    logic             done_flag;
    logic             addr_ok, fifo_hit, dig_hit;
    logic             wr_cfg, wr_ie, wr_flag, wr_cmd;
    logic             cmd_start, cmd_proc, push_byte, push_word;
    logic             buf_clear, latch_res, ovf;
    logic [CNT_W-1:0] count;
    logic [SEL_W-1:0] dig_sel;
    logic [31:0]      dig_word;

    // Address decode and write strobes.
    always_comb begin
        addr_ok   = (bus_addr < ADDR_W'(WIN_END)) && (bus_addr[1:0] == 2'b00);
        bus_err   = (bus_we || bus_re) && !addr_ok;
        fifo_hit  = addr_ok && (bus_addr >= ADDR_W'(OFF_FIFO));
        dig_hit   = addr_ok && (bus_addr >= ADDR_W'(OFF_DIGLO)) && (bus_addr <= ADDR_W'(OFF_DIGHI));
        dig_sel   = SEL_W'((ADDR_W'(OFF_DIGHI) - bus_addr) >> 2);
        wr_cfg    = bus_we && addr_ok && (bus_addr == ADDR_W'(OFF_CFG));
        wr_ie     = bus_we && addr_ok && (bus_addr == ADDR_W'(OFF_IE));
        wr_flag   = bus_we && addr_ok && (bus_addr == ADDR_W'(OFF_FLAG));
        wr_cmd    = bus_we && addr_ok && (bus_addr == ADDR_W'(OFF_CMD));
        cmd_start = wr_cmd && bus_wdata[0];
        cmd_proc  = wr_cmd && bus_wdata[1];
        push_byte = bus_we && fifo_hit && !bus_wsize && (state == ST_CONS);
        push_word = bus_we && fifo_hit &&  bus_wsize && (state == ST_CONS);
    end

    // Options and interrupt mask, writable only while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            ie  <= '0;
        end else if (state == ST_IDLE) begin
            if (wr_cfg) cfg <= bus_wdata[3:0];
            if (wr_ie)  ie  <= bus_wdata[2:0];
        end
    end

    // Done flag: set by engine completion, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done_flag <= 1'b0;
        else if (latch_res)             done_flag <= 1'b1;
        else if (wr_flag && bus_wdata[0]) done_flag <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_re && addr_ok) begin
            if (bus_addr == ADDR_W'(OFF_CFG))       bus_rdata = {28'd0, cfg};
            else if (bus_addr == ADDR_W'(OFF_IE))   bus_rdata = {29'd0, ie};
            else if (bus_addr == ADDR_W'(OFF_FLAG)) bus_rdata = {31'd0, done_flag};
            else if (bus_addr == ADDR_W'(OFF_STAT))
                bus_rdata = {17'd0, count, 5'd0, ovf, state};
            else if (dig_hit && state == ST_IDLE)   bus_rdata = dig_word;
        end
    end

    assign eng_len = count;
    assign eng_cfg = cfg;

    hfe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_proc  (cmd_proc),
        .eng_done  (eng_done),
        .state     (state),
        .eng_start (eng_start),
        .buf_clear (buf_clear),
        .latch_res (latch_res)
    );

    hfe_msg_buf #(.MAX_BYTES(MAX_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .push_byte (push_byte),
        .push_word (push_word),
        .wdata     (bus_wdata),
        .msg       (eng_msg),
        .count     (count),
        .ovf       (ovf)
    );

    hfe_result #(.WORDS(DIG_WORDS)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .latch (latch_res),
        .din   (eng_digest),
        .sel   (dig_sel),
        .dout  (dig_word)
    );
endmodule

// File: rtl/hfe_checker.sv
// Cycle-by-cycle rules of the hash front-end, bound into every instance of the top.
// Assumes it observes the top's sequencer state, options, flag and fill count.
module hfe_checker
    import hfe_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MAX_BYTES = 64,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [3:0]        cfg,
    input logic              done_flag,
    input logic [CNT_W-1:0]  count,
    input logic              eng_start,
    input logic              eng_done,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_err,
    input logic [31:0]       bus_rdata
);
    // R2: options frozen outside the waiting state
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cfg));

    // R3: writing one clears the done flag unless completion arrives together
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_FLAG) && bus_wdata[0]
         && !(state == ST_PROC && eng_done)) |=> !done_flag);

    // R5: fill level does not move while working
    p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROC) |=> $stable(count));

    // R6: engine start is a single pulse issued while working
    p_start_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (state == ST_PROC));
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R7: completion sets the flag and returns to waiting
    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROC && eng_done) |=> (done_flag && state == ST_IDLE));

    // R9: the buffer never reports more than it holds
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_BYTES));

    // R10: an address error never returns data
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'd0));
endmodule

bind hash_frontend hfe_checker #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cfg       (cfg),
    .done_flag (done_flag),
    .count     (count),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata)
);

// File: tb/hash_frontend_tb.sv
// Directed bench for the hash front-end with a small engine model.
module hash_frontend_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0, bus_re = 1'b0, bus_wsize = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic         eng_start;
    logic [6:0]   eng_len;
    logic [511:0] eng_msg;
    logic [3:0]   eng_cfg;
    logic         eng_done = 1'b0;
    logic [255:0] eng_digest = '0;

    int tests = 0, fails = 0, runs = 0;
    logic [6:0]   cap_len;
    logic [511:0] cap_msg;
    logic         last_err;
    logic [31:0]  rd;

    always #5 clk = ~clk;

    hash_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wsize(bus_wsize), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .eng_start(eng_start),
        .eng_len(eng_len), .eng_msg(eng_msg), .eng_cfg(eng_cfg),
        .eng_done(eng_done), .eng_digest(eng_digest)
    );

    function automatic logic [31:0] res_word(int run, int i);
        return {8'(run), 8'(i), 16'hBEEF};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic sz);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wsize = sz;
        #1 last_err = bus_err;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdr(logic [11:0] a);
        bus_re = 1'b1; bus_addr = a;
        #1 rd = bus_rdata; last_err = bus_err;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 30; n++) begin
            rdr(12'h008);
            if (rd[0]) break;
        end
    endtask

    // Engine model: answer every start after a few cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_start) begin
                runs++;
                cap_len = eng_len;
                cap_msg = eng_msg;
                repeat (3) @(negedge clk);
                for (int i = 0; i < 8; i++) eng_digest[32*i +: 32] = res_word(runs, i);
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    task automatic t_reset();
        rdr(12'h000); check("R1 options", rd, 0);
        rdr(12'h004); check("R1 mask", rd, 0);
        rdr(12'h008); check("R1 flags", rd, 0);
        rdr(12'h010); check("R1 status", rd, 0);
    endtask

    task automatic t_options();
        wr(12'h000, 32'hFFFF_FFF5, 0); rdr(12'h000); check("R2 options low bits", rd, 32'h5);
        wr(12'h004, 32'hFFFF_FFFF, 0); rdr(12'h004); check("R2 mask low bits", rd, 32'h7);
    endtask

    task automatic t_job();
        int r0;
        r0 = runs;
        wr(12'h00C, 32'h1, 0); rdr(12'h010); check("R4 start to collecting", rd, 32'h1);
        wr(12'h000, 32'h0, 0); rdr(12'h000); check("R2 options frozen", rd, 32'h5);
        wr(12'h004, 32'h0, 0); rdr(12'h004); check("R2 mask frozen", rd, 32'h7);
        rdr(12'h03C); check("R8 result hidden while collecting", rd, 0);
        wr(12'h00C, 32'h1, 0); rdr(12'h010); check("R4 start ignored while collecting", rd, 32'h1);
        wr(12'h040, 32'h1234_56AB, 0);
        wr(12'h05C, 32'h4433_2211, 1);
        rdr(12'h010); check("R5 count after byte and word", rd, {17'd0, 7'd5, 5'd0, 1'b0, 2'd1});
        wr(12'h00C, 32'h2, 0);
        rdr(12'h010); check("R6 working", rd[1:0], 2'd2);
        wr(12'h040, 32'hFF, 0);
        wr(12'h00C, 32'h1, 0);
        rdr(12'h010); check("R5/R4 pushes and start ignored while working", rd[14:0], {7'd5, 5'd0, 1'b0, 2'd2});
        wait_done();
        check("R7 done flag", rd, 32'h1);
        check("R6 one start per job", 32'(runs - r0), 1);
        check("R6 length", 32'(cap_len), 5);
        check("R5 stream order", cap_msg[39:0], 40'h44_33_22_11_AB);
        rdr(12'h010); check("R7 back to waiting", rd[1:0], 2'd0);
        for (int i = 0; i < 8; i++) begin
            rdr(12'(32'h3C - 4 * i));
            check($sformatf("R8 result word %0d", i), rd, res_word(runs, i));
        end
        wr(12'h040, 32'h77, 0); rdr(12'h010);
        check("R5 push ignored while waiting", rd[14:8], 7'd5);
        wr(12'h00C, 32'h2, 0); rdr(12'h010);
        check("R6 process ignored while waiting", rd[1:0], 2'd0);
        wr(12'h008, 32'hFFFF_FFFE, 0); rdr(12'h008); check("R3 write zero keeps flag", rd, 32'h1);
        wr(12'h008, 32'h1, 0); rdr(12'h008); check("R3 write one clears flag", rd, 32'h0);
    endtask

    task automatic t_overflow();
        wr(12'h00C, 32'h1, 0);
        rdr(12'h010); check("R4 start empties buffer", rd[14:8], 7'd0);
        for (int k = 0; k < 15; k++) wr(12'h040, 32'h0403_0201 + 32'(k), 1);
        wr(12'h040, 32'h10, 0);
        wr(12'h040, 32'h11, 0);
        wr(12'h040, 32'hAAAA_AAAA, 1);
        rdr(12'h010); check("R9 word dropped whole at 62", rd[14:0], {7'd62, 5'd0, 1'b1, 2'd1});
        wr(12'h040, 32'h20, 0);
        wr(12'h040, 32'h21, 0);
        wr(12'h040, 32'h22, 0);
        rdr(12'h010); check("R9 full at 64, overflow sticky", rd[14:0], {7'd64, 5'd0, 1'b1, 2'd1});
        wr(12'h00C, 32'h2, 0);
        wait_done();
        check("R9 last bytes kept, extra dropped", {16'd0, cap_msg[511:496]}, 32'h2120);
        check("R6 full length", 32'(cap_len), 64);
        wr(12'h008, 32'h1, 0);
        wr(12'h00C, 32'h1, 0);
        rdr(12'h010); check("R4 start clears overflow", rd[14:0], {7'd0, 5'd0, 1'b0, 2'd1});
        wr(12'h00C, 32'h2, 0);
        wait_done();
        wr(12'h008, 32'h1, 0);
    endtask

    task automatic t_badaddr();
        rdr(12'h080); check("R10 error beyond window", 32'(last_err), 1);
        check("R10 reads zero", rd, 0);
        wr(12'h001, 32'h0, 0); check("R10 error unaligned", 32'(last_err), 1);
        rdr(12'h000); check("R10 unaligned write ignored", rd, 32'h5);
        wr(12'h00D, 32'h1, 0); rdr(12'h010);
        check("R10 unaligned command ignored", rd[1:0], 2'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_options();
        t_job();
        t_overflow();
        t_badaddr();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule